// File: doc/BRIEF.md
# Per-Pin Timed Event Sequencer

This block drives one tester pin from a list of timed events. Each event pairs a target state with a time offset, in fine units, measured from the start of a test period. A table in the block stores several such lists. A global period marker starts a new period: with the marker come a sub-clock vernier offset and a global selector that picks which list the pin plays in that period. The block adds the vernier to each event's offset. The upper bits of the sum pick the master-clock cycle in which the state change is emitted. The lower five bits go out beside it as a fine-delay code for an analog delay line that sits outside the block.

A list is not tied to a fixed waveform format and has no fixed edge count. Up to the storage depth, any number of drive and compare changes may fall in one period, in the order a logic simulator would list them. Drive events update a held drive-enable/drive-value pair. Compare events go out as a two-bit mode with a one-cycle valid pulse. The event outputs carry no ready signal: a state change is bound to its clock cycle and cannot be held back, so a receiver must accept every pulse in the cycle it occurs. The table is loaded through a plain write port that is expected to be idle while the pin is playing.

Top module: `pin_event_sequencer`

## Requirements
- R1: An event with offset `o` in a period whose marker carried vernier `v` falls in cycle `c = (v+o) >> 5`. Its output is visible after rising edge number `c+1` that follows the edge sampling `period_start`. A vernier carry moves the event into the next cycle.
- R2: `evt_fine` shows `(v+o) & 31` in the same cycle as the event's `drv_upd` or `cmp_valid` pulse.
- R3: Drive codes: 0 sets `drv_en`=1 and `drv_val`=1; 1 sets `drv_en`=1 and `drv_val`=0; 2 clears `drv_en` and keeps `drv_val`. Each of these pulses `drv_upd` for one cycle.
- R4: Compare codes 3 (test high), 4 (test low), 5 (test Z) and 6 (end test) pulse `cmp_valid` for one cycle with `cmp_mode` equal to code minus 3. Code 7 produces no output.
- R5: Playback of a list stops at the entry whose last flag is set. Entries stored after it are never emitted.
- R6: A list of drive-high at cycle 1, drive-low at 8, drive-high at 13 and drive-low at 18 (vernier 0) drives the pin high, low, high, low on exactly those cycles.
- R7: When two adjacent list entries resolve to the same cycle, only the later entry is emitted, and the sticky `collide` flag is set.
- R8: Events whose cycle is not reached before the next marker are dropped, and the sticky `overrun` flag is set. A list that has finished by then leaves the flag clear.
- R9: `vec_sel` and `vernier` are sampled only in the cycle of `period_start`. Changing them later in the period has no effect on the events played.
- R10: After reset, all outputs and both flags are 0, and nothing is emitted until the first marker.
- R11: At most one of `drv_upd` and `cmp_valid` is high in any cycle. `drv_en` and `drv_val` change only in a cycle with `drv_upd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_seq | input | SEL_W | List number being written |
| cfg_idx | input | IDX_W | Entry slot within the list |
| cfg_code | input | 3 | State code of the entry |
| cfg_last | input | 1 | Marks the final entry of the list |
| cfg_ofs | input | CYC_W+FINE_W | Time offset in fine units |
| period_start | input | 1 | Period time-zero marker |
| vernier | input | FINE_W | Sub-cycle start offset of the period |
| vec_sel | input | SEL_W | List selected for this period |
| drv_upd | output | 1 | Drive state changed this cycle |
| drv_en | output | 1 | Pin driver enabled |
| drv_val | output | 1 | Driven logic level |
| cmp_valid | output | 1 | Compare command pulse |
| cmp_mode | output | 2 | 0 high, 1 low, 2 Z, 3 end test |
| evt_fine | output | FINE_W | Fine-delay code of the current event |
| overrun | output | 1 | Sticky: events were dropped |
| collide | output | 1 | Sticky: same-cycle events occurred |

## Verification
The bench uses the defaults: four lists of eight entries, five fine bits and five cycle bits. Offsets therefore reach 31 cycles, which leaves room for the 18-cycle reference waveform and for an event cut off at cycle 20 by a 10-cycle period. A vernier of 30 or 31 pushes sums across a cycle boundary, so the carry path is exercised. Eight slots allow a list to stop early and still hold stale entries after its last flag.

// File: rtl/pes_pkg.sv
`timescale 1ns/1ps
package pes_pkg;
  typedef enum logic [2:0] {
    EV_DRV_HI  = 3'd0,
    EV_DRV_LO  = 3'd1,
    EV_DRV_OFF = 3'd2,
    EV_CMP_HI  = 3'd3,
    EV_CMP_LO  = 3'd4,
    EV_CMP_Z   = 3'd5,
    EV_CMP_END = 3'd6,
    EV_NOP     = 3'd7
  } evt_code_e;
endpackage

// File: rtl/pes_store.sv
`timescale 1ns/1ps
// Event table: one write port, whole-list combinational read.
module pes_store #(
  parameter int NSEQ  = 4,
  parameter int NEVT  = 8,
  parameter int OFS_W = 10,
  localparam int SEL_W = (NSEQ > 1) ? $clog2(NSEQ) : 1,
  localparam int IDX_W = (NEVT > 1) ? $clog2(NEVT) : 1
) (
  input  logic                        clk,
  input  logic                        we,
  input  logic [SEL_W-1:0]            wseq,
  input  logic [IDX_W-1:0]            widx,
  input  logic [2:0]                  wcode,
  input  logic                        wlast,
  input  logic [OFS_W-1:0]            wofs,
  input  logic [SEL_W-1:0]            rseq,
  output logic [NEVT-1:0][2:0]        rd_code,
  output logic [NEVT-1:0]             rd_last,
  output logic [NEVT-1:0][OFS_W-1:0]  rd_ofs
);
  logic [NSEQ-1:0][NEVT-1:0][2:0]       code_q;
  logic [NSEQ-1:0][NEVT-1:0]            last_q;
  logic [NSEQ-1:0][NEVT-1:0][OFS_W-1:0] ofs_q;

  always_ff @(posedge clk) begin
    if (we) begin
      code_q[wseq][widx] <= wcode;
      last_q[wseq][widx] <= wlast;
      ofs_q[wseq][widx]  <= wofs;
    end
  end

  assign rd_code = code_q[rseq];
  assign rd_last = last_q[rseq];
  assign rd_ofs  = ofs_q[rseq];
endmodule

// File: rtl/pes_ctl.sv
`timescale 1ns/1ps
// Period tracking: captures vernier and selector at the marker, counts cycles.
module pes_ctl #(
  parameter int SEL_W  = 2,
  parameter int FINE_W = 5,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [FINE_W-1:0] vern_in,
  input  logic [SEL_W-1:0]  sel_in,
  output logic              active,
  output logic [CNT_W-1:0]  cnt,
  output logic [FINE_W-1:0] vern,
  output logic [SEL_W-1:0]  sel
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      vern   <= '0;
      sel    <= '0;
    end else if (start) begin
      active <= 1'b1;
      cnt    <= '0;
      vern   <= vern_in;
      sel    <= sel_in;
    end else if (active && (cnt != '1)) begin
      cnt <= cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/pes_match.sv
`timescale 1ns/1ps
// Resolves every live entry to a cycle and picks the event for the current one.
module pes_match #(
  parameter int NEVT   = 8,
  parameter int OFS_W  = 10,
  parameter int FINE_W = 5,
  parameter int CNT_W  = 6
) (
  input  logic                        active,
  input  logic [CNT_W-1:0]            cnt,
  input  logic [FINE_W-1:0]           vern,
  input  logic [NEVT-1:0][2:0]        ev_code,
  input  logic [NEVT-1:0]             ev_last,
  input  logic [NEVT-1:0][OFS_W-1:0]  ev_ofs,
  output logic                        hit,
  output logic [2:0]                  hit_code,
  output logic [FINE_W-1:0]           hit_fine,
  output logic                        multi,
  output logic                        pending
);
  localparam int TS_W = OFS_W + 1;
  localparam int NM_W = $clog2(NEVT + 1);

  logic [NEVT-1:0]             live, match, later;
  logic [NEVT-1:0][FINE_W-1:0] fine;
  logic                        run;
  logic [NM_W-1:0]             nm;

  // an entry is live while no earlier entry carries the last flag
  always_comb begin
    run = 1'b1;
    for (int i = 0; i < NEVT; i++) begin
      live[i] = run;
      run     = run & ~ev_last[i];
    end
  end

  for (genvar g = 0; g < NEVT; g++) begin : g_evt
    logic [TS_W-1:0] ts;
    assign ts       = {1'b0, ev_ofs[g]} + TS_W'(vern);
    assign fine[g]  = ts[FINE_W-1:0];
    assign match[g] = active & live[g] & (ts[TS_W-1:FINE_W] == cnt);
    assign later[g] = active & live[g] & (ts[TS_W-1:FINE_W] > cnt);
  end

  // the highest-index match wins: later list entry overrides earlier
  always_comb begin
    hit      = 1'b0;
    hit_code = 3'd7;
    hit_fine = '0;
    nm       = '0;
    for (int i = 0; i < NEVT; i++) begin
      if (match[i]) begin
        hit      = 1'b1;
        hit_code = ev_code[i];
        hit_fine = fine[i];
        nm       = nm + NM_W'(1);
      end
    end
  end

  assign multi   = (nm > NM_W'(1));
  assign pending = |later;
endmodule

// File: rtl/pin_event_sequencer.sv
`timescale 1ns/1ps
module pin_event_sequencer #(
  parameter int NSEQ   = 4,
  parameter int NEVT   = 8,
  parameter int FINE_W = 5,
  parameter int CYC_W  = 5,
  localparam int SEL_W = (NSEQ > 1) ? $clog2(NSEQ) : 1,
  localparam int IDX_W = (NEVT > 1) ? $clog2(NEVT) : 1,
  localparam int OFS_W = CYC_W + FINE_W,
  localparam int CNT_W = CYC_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_seq,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [2:0]        cfg_code,
  input  logic              cfg_last,
  input  logic [OFS_W-1:0]  cfg_ofs,
  input  logic              period_start,
  input  logic [FINE_W-1:0] vernier,
  input  logic [SEL_W-1:0]  vec_sel,
  output logic              drv_upd,
  output logic              drv_en,
  output logic              drv_val,
  output logic              cmp_valid,
  output logic [1:0]        cmp_mode,
  output logic [FINE_W-1:0] evt_fine,
  output logic              overrun,
  output logic              collide
);
  import pes_pkg::*;

  logic                       active;
  logic [CNT_W-1:0]           cnt;
  logic [FINE_W-1:0]          vern;
  logic [SEL_W-1:0]           sel;
  logic [NEVT-1:0][2:0]       ev_code;
  logic [NEVT-1:0]            ev_last;
  logic [NEVT-1:0][OFS_W-1:0] ev_ofs;
  logic                       hit, multi, pending;
  logic [2:0]                 hit_code;
  logic [FINE_W-1:0]          hit_fine;
  evt_code_e                  code;

  pes_ctl #(.SEL_W(SEL_W), .FINE_W(FINE_W), .CNT_W(CNT_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .start(period_start), .vern_in(vernier),
    .sel_in(vec_sel), .active(active), .cnt(cnt), .vern(vern), .sel(sel)
  );

  pes_store #(.NSEQ(NSEQ), .NEVT(NEVT), .OFS_W(OFS_W)) u_store (
    .clk(clk), .we(cfg_we), .wseq(cfg_seq), .widx(cfg_idx), .wcode(cfg_code),
    .wlast(cfg_last), .wofs(cfg_ofs), .rseq(sel),
    .rd_code(ev_code), .rd_last(ev_last), .rd_ofs(ev_ofs)
  );

  pes_match #(.NEVT(NEVT), .OFS_W(OFS_W), .FINE_W(FINE_W), .CNT_W(CNT_W)) u_match (
    .active(active), .cnt(cnt), .vern(vern), .ev_code(ev_code),
    .ev_last(ev_last), .ev_ofs(ev_ofs), .hit(hit), .hit_code(hit_code),
    .hit_fine(hit_fine), .multi(multi), .pending(pending)
  );

  assign code = evt_code_e'(hit_code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_upd   <= 1'b0;
      drv_en    <= 1'b0;
      drv_val   <= 1'b0;
      cmp_valid <= 1'b0;
      cmp_mode  <= 2'd0;
      evt_fine  <= '0;
      overrun   <= 1'b0;
      collide   <= 1'b0;
    end else begin
      drv_upd   <= 1'b0;
      cmp_valid <= 1'b0;
      if (hit) begin
        evt_fine <= hit_fine;
        unique case (code)
          EV_DRV_HI:  begin drv_upd <= 1'b1; drv_en <= 1'b1; drv_val <= 1'b1; end
          EV_DRV_LO:  begin drv_upd <= 1'b1; drv_en <= 1'b1; drv_val <= 1'b0; end
          EV_DRV_OFF: begin drv_upd <= 1'b1; drv_en <= 1'b0; end
          EV_CMP_HI:  begin cmp_valid <= 1'b1; cmp_mode <= 2'd0; end
          EV_CMP_LO:  begin cmp_valid <= 1'b1; cmp_mode <= 2'd1; end
          EV_CMP_Z:   begin cmp_valid <= 1'b1; cmp_mode <= 2'd2; end
          EV_CMP_END: begin cmp_valid <= 1'b1; cmp_mode <= 2'd3; end
          EV_NOP:     ;
        endcase
        if (multi) collide <= 1'b1;
      end
      if (period_start && pending) overrun <= 1'b1;
    end
  end
endmodule

// File: rtl/pes_chk.sv
`timescale 1ns/1ps
module pes_chk (
  input logic clk,
  input logic rst_n,
  input logic drv_upd,
  input logic drv_en,
  input logic drv_val,
  input logic cmp_valid,
  input logic overrun,
  input logic collide
);
  // R11
  one_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(drv_upd && cmp_valid));
  // R11
  drv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_upd |-> ($stable(drv_en) && $stable(drv_val)));
  // R8
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
  // R7
  coll_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    collide |=> collide);
endmodule

bind pin_event_sequencer pes_chk u_chk (
  .clk(clk), .rst_n(rst_n), .drv_upd(drv_upd), .drv_en(drv_en),
  .drv_val(drv_val), .cmp_valid(cmp_valid), .overrun(overrun), .collide(collide)
);

// File: tb/pin_event_sequencer_bench.sv
`timescale 1ns/1ps
module pin_event_sequencer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_seq = '0;
  logic [2:0] cfg_idx = '0;
  logic [2:0] cfg_code = '0;
  logic       cfg_last = 1'b0;
  logic [9:0] cfg_ofs = '0;
  logic       period_start = 1'b0;
  logic [4:0] vernier = '0;
  logic [1:0] vec_sel = '0;
  logic       drv_upd, drv_en, drv_val, cmp_valid, overrun, collide;
  logic [1:0] cmp_mode;
  logic [4:0] evt_fine;

  pin_event_sequencer u_pin_event_sequencer (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_seq(cfg_seq),
    .cfg_idx(cfg_idx), .cfg_code(cfg_code), .cfg_last(cfg_last),
    .cfg_ofs(cfg_ofs), .period_start(period_start), .vernier(vernier),
    .vec_sel(vec_sel), .drv_upd(drv_upd), .drv_en(drv_en), .drv_val(drv_val),
    .cmp_valid(cmp_valid), .cmp_mode(cmp_mode), .evt_fine(evt_fine),
    .overrun(overrun), .collide(collide)
  );

  always #4 clk = ~clk;

  typedef struct {
    int    cyc;
    bit    is_cmp;
    int    a;
    int    b;
    int    fine;
    string tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  int   cyc = 0;
  bit   done = 0;
  int   m_code [4][8];
  bit   m_last [4][8];
  int   m_ofs  [4][8];
  bit   cur_val = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && (drv_upd || cmp_valid)) begin
      if (q.size() == 0) begin
        chk("R5", "unexpected event at cycle", cyc, -1);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(e.tag, "event cycle", cyc, e.cyc);
        chk(e.tag, "event is compare", int'(cmp_valid), int'(e.is_cmp));
        chk(e.tag, "fine code (R2)", int'(evt_fine), e.fine);
        if (e.is_cmp) chk(e.tag, "cmp_mode (R4)", int'(cmp_mode), e.a);
        else begin
          chk(e.tag, "drv_en (R3)", int'(drv_en), e.a);
          chk(e.tag, "drv_val (R3)", int'(drv_val), e.b);
        end
      end
    end
  end

  task automatic write_evt(int s, int i, int code, bit last, int ofs);
    m_code[s][i] = code; m_last[s][i] = last; m_ofs[s][i] = ofs;
    cfg_we = 1; cfg_seq = 2'(s); cfg_idx = 3'(i);
    cfg_code = 3'(code); cfg_last = last; cfg_ofs = 10'(ofs);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic push(int c, int code, int fine, string tag);
    exp_t e;
    e.cyc = c; e.fine = fine; e.tag = tag; e.b = 0;
    if (code <= 2) begin
      e.is_cmp = 0;
      if (code == 0) cur_val = 1;
      if (code == 1) cur_val = 0;
      e.a = (code == 2) ? 0 : 1;
      e.b = int'(cur_val);
      q.push_back(e);
    end else if (code <= 6) begin
      e.is_cmp = 1;
      e.a = code - 3;
      q.push_back(e);
    end
  endtask

  // driver: marker, expected events, then the selector is scrambled (R9)
  task automatic run_period(int s, int v, int len, string tag);
    int k;
    k = cyc;
    period_start = 1; vernier = 5'(v); vec_sel = 2'(s);
    for (int i = 0; i < 8; i++) begin
      int  t;
      int  c;
      bit  skip;
      t = v + m_ofs[s][i];
      c = t / 32;
      skip = 0;
      if (i < 7 && !m_last[s][i] && ((v + m_ofs[s][i+1]) / 32 == c)) skip = 1;
      if (!skip && c < len) push(k + 2 + c, m_code[s][i], t % 32, tag);
      if (m_last[s][i]) break;
    end
    @(negedge clk);
    period_start = 0;
    vec_sel = 2'((s + 1) % 4);
    vernier = 5'(31 - v);
    repeat (len - 1) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10", "drv_en", int'(drv_en), 0);
    chk("R10", "drv_upd", int'(drv_upd), 0);
    chk("R10", "cmp_valid", int'(cmp_valid), 0);
    rst_n = 1;
    @(negedge clk);
    // list 0: reference waveform (R6)
    write_evt(0, 0, 0, 0, 1 * 32);
    write_evt(0, 1, 1, 0, 8 * 32);
    write_evt(0, 2, 0, 0, 13 * 32);
    write_evt(0, 3, 1, 1, 18 * 32);
    // list 1: compare codes, carry, stale entry after last (R4, R5, R1)
    write_evt(1, 0, 3, 0, 2 * 32);
    write_evt(1, 1, 5, 0, 3 * 32 + 5);
    write_evt(1, 2, 2, 0, 4 * 32);
    write_evt(1, 3, 4, 0, 5 * 32 + 31);
    write_evt(1, 4, 6, 1, 7 * 32);
    write_evt(1, 5, 0, 0, 8 * 32);
    // list 2: same-cycle pair (R7)
    write_evt(2, 0, 0, 0, 5);
    write_evt(2, 1, 0, 0, 2 * 32);
    write_evt(2, 2, 1, 0, 2 * 32 + 1);
    write_evt(2, 3, 2, 1, 4 * 32);
    // list 3: late event cut by next marker (R8)
    write_evt(3, 0, 0, 0, 32);
    write_evt(3, 1, 1, 1, 20 * 32);
    repeat (5) @(negedge clk);
    chk("R10", "no event before first marker", q.size(), 0);
    chk("R10", "overrun", int'(overrun), 0);
    chk("R10", "collide", int'(collide), 0);

    run_period(0, 0, 22, "R6");
    run_period(0, 7, 22, "R2");
    run_period(1, 3, 12, "R4");
    chk("R8", "overrun after finished lists", int'(overrun), 0);
    chk("R7", "collide before pair", int'(collide), 0);
    run_period(2, 30, 8, "R7");
    chk("R7", "collide after pair", int'(collide), 1);
    chk("R8", "overrun before cut", int'(overrun), 0);
    run_period(3, 0, 10, "R8");
    run_period(0, 0, 22, "R9");
    chk("R8", "overrun after cut", int'(overrun), 1);
    repeat (30) @(negedge clk);
    chk("R1", "pending expected events", q.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule